// File: doc/BRIEF.md
# DS1 Framed Test-Pattern Generator with Error Injection

This block produces a serial DS1-rate test stream for bit-error-rate testing. Each bit slot is marked by a bit-enable strobe. The stream can be sent unframed, in a 12-frame superframe format, or in a 24-frame extended superframe format. In the extended format, a CRC-6 checksum of the previous superframe travels in dedicated framing slots. The payload is either a 2^15-1 pseudo-random sequence or all ones. Outputs are a data bit, a bit-clock strobe and a superframe sync pulse.

Test equipment can corrupt the stream on demand, one event at a time. A single payload bit error is injected on each rising edge of a shared trigger, but only while this generator's bit-error enable is set. A rising edge of the framing-error control corrupts one framing bit. A rising edge of the CRC-error control corrupts one transmitted checksum bit without disturbing the running checksum.

A second, independent output carries a 12-frame-superframe idle stream whose payload is a repeating octet. It has its own clock strobe and sync pulse. The block raises no interrupts.

Top module: `ds1_pattern_gen`

## Requirements
- R1: While `rstN` is low, `txData`, `txSync`, `lineClk`, `idleData`, `idleSync` and `idleClk` are 0, and all counters, pending events and checksum registers clear.
- R2: With `frameMode` 2'b00 or 2'b11 (unframed), every bit is payload and `txSync` stays low. The PRBS register is 15 bits, seeded with `PRBS_SEED`. It outputs stage 14 and shifts left, inserting stage14 XOR stage13 (x^15+x^14+1).
- R3: With `frameMode` 2'b01, frames are 193 bits, with a framing bit first and 192 payload bits after it. Over the 12 frames the framing bits are 1,0,0,0,1,1,0,1,1,1,0,0, frame 0 first. The PRBS does not advance in framing slots.
- R4: With `frameMode` 2'b10, superframes are 24 frames. In a frame with index n counted from 0, the framing slot carries a value set by n mod 4. When n mod 4 = 3 it carries pattern bit n/4 of 0,0,1,0,1,1. When n mod 4 = 1 it carries checksum bit n/4, most significant first. Otherwise it carries 1. The checksum is a CRC-6 (x^6+x+1) with a zero start value. It is computed over the previous superframe's 4632 bits as transmitted, with framing slots counted as 1. The first superframe after reset carries zeros.
- R5: A rising edge of `berTrig` while `berEnable` is 1 inverts exactly the next payload bit launched after the edge. A rising edge while `berEnable` is 0 has no effect. Edges are detected whether or not `bitEn` is high.
- R6: `txSync` is high for one clock, together with the framing bit of frame 0, in framed modes.
- R7: A rising edge of `ferCtl` inverts one framing bit in the framed modes. In mode 2'b01 this is the next framing bit. In mode 2'b10 it is the next pattern-carrying slot. In unframed mode the edge is ignored.
- R8: A rising edge of `crcCtl` in mode 2'b10 inverts the next transmitted checksum bit and leaves the running checksum unchanged. In the other modes the edge is ignored.
- R9: With `patSel` = 1, every payload bit is 1. With `patSel` = 0, payload bits come from the PRBS.
- R10: A bit is launched only on a clock where `bitEn` = 1. `lineClk` and `idleClk` are 1 for the clock that follows each launch and 0 otherwise. Data outputs hold their values between launches.
- R11: The idle output always uses the 12-frame format of R3, with its own frame count and a payload of repeated `IDLE_OCTET` sent most significant bit first. `idleSync` pulses with the framing bit of its frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Launch one bit on this clock |
| frameMode | input | 2 | 00/11 unframed, 01 12-frame, 10 24-frame with CRC-6 |
| patSel | input | 1 | 0 PRBS payload, 1 all-ones payload |
| berEnable | input | 1 | Per-generator bit-error enable |
| berTrig | input | 1 | Shared bit-error trigger, rising edge |
| ferCtl | input | 1 | Framing-error trigger, rising edge |
| crcCtl | input | 1 | Checksum-error trigger, rising edge |
| txData | output | 1 | Test stream data |
| txSync | output | 1 | Superframe sync pulse |
| lineClk | output | 1 | Test stream bit strobe |
| idleData | output | 1 | Idle stream data |
| idleSync | output | 1 | Idle superframe sync pulse |
| idleClk | output | 1 | Idle stream bit strobe |

## Verification
The bench overrides `PRBS_SEED` with 15'h1234 and keeps `IDLE_OCTET` at 8'h7F. A seed other than all ones makes a stuck or mis-seeded shift register visible within the first few bits. The 0x7F octet places a single zero at a fixed bit position, so a reversed bit order or an off-by-one payload index shows up at once. The frame sizes are fixed by the line format, so full superframes of 2316 and 4632 bits are run. This lets checksum carry-over between consecutive superframes and injection into late framing slots be observed directly.

// File: rtl/ds1_tpg_pkg.sv
package ds1_tpg_pkg;

  localparam int FRAME_BITS = 193;
  localparam int SF_FRAMES  = 12;
  localparam int ESF_FRAMES = 24;
  localparam int PRBS_W     = 15;
  localparam int CRC_W      = 6;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int FRM_W      = $clog2(ESF_FRAMES);

  // framing bit per frame of the 12-frame format, frame 0 in bit 0 (padded)
  localparam logic [15:0] SF_FBITS = 16'h03B1;
  // pattern bits of the 24-frame format, slot 0 in bit 0 (padded)
  localparam logic [7:0]  ESF_PAT  = 8'h34;
  localparam logic [CRC_W-1:0] CRC_POLY = 6'b000011;

  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_SF   = 2'b01,
    MODE_ESF  = 2'b10,
    MODE_RSVD = 2'b11
  } frameMode_e;

  typedef struct packed {
    logic       adv;       // launch a bit this clock
    logic       payload;   // slot carries payload
    logic       fbitVal;   // framing value for non-checksum slots
    logic       crcSlot;   // slot carries a checksum bit
    logic [2:0] crcIdx;    // which checksum bit, 0 = most significant
    logic       sfStart;   // first bit of a superframe
    logic       sfEnd;     // last bit of a superframe
    logic       flipPay;   // invert this payload bit
    logic       flipFrm;   // invert this framing bit
    logic       flipCrc;   // invert this checksum bit
    logic       idleFbit;  // idle stream framing slot
    logic       idleFval;  // idle framing value
    logic [2:0] idleIdx;   // idle payload bit within octet
    logic       idleStart; // idle superframe start
  } strobe_t;

endpackage

// File: rtl/ds1_tpg_ctrl.sv
module ds1_tpg_ctrl
  import ds1_tpg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic [1:0] frameMode,
  input  logic       berEnable,
  input  logic       berTrig,
  input  logic       ferCtl,
  input  logic       crcCtl,
  output strobe_t    stb
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [FRM_W-1:0] SF_LAST  = FRM_W'(SF_FRAMES - 1);
  localparam logic [FRM_W-1:0] ESF_LAST = FRM_W'(ESF_FRAMES - 1);
  localparam logic [3:0]       IDLE_LAST = 4'(SF_FRAMES - 1);

  logic [BIT_W-1:0] bitCnt;
  logic [FRM_W-1:0] frmCnt;
  logic [3:0]       idleFrm;
  logic berQ, ferQ, crcQ;
  logic berPend, ferPend, crcPend;

  logic framed, esf, fSlot, patSlot, crcSlot, lastBit, lastFrm;
  logic [FRM_W-1:0] frmLast;
  logic berRise, ferRise, crcRise;

  always_comb begin
    framed  = (frameMode == MODE_SF) || (frameMode == MODE_ESF);
    esf     = (frameMode == MODE_ESF);
    fSlot   = framed && (bitCnt == '0);
    crcSlot = esf && fSlot && (frmCnt[1:0] == 2'd1);
    patSlot = fSlot && (!esf || (frmCnt[1:0] == 2'd3));
    frmLast = esf ? ESF_LAST : SF_LAST;
    lastBit = (bitCnt == LAST_BIT);
    lastFrm = (frmCnt == frmLast);
    berRise = berTrig && !berQ && berEnable;
    ferRise = ferCtl && !ferQ && framed;
    crcRise = crcCtl && !crcQ && esf;

    stb.adv       = bitEn;
    stb.payload   = !fSlot;
    stb.fbitVal   = esf ? ((frmCnt[1:0] == 2'd3) ? ESF_PAT[frmCnt[4:2]] : 1'b1)
                        : SF_FBITS[frmCnt[3:0]];
    stb.crcSlot   = crcSlot;
    stb.crcIdx    = frmCnt[4:2];
    stb.sfStart   = fSlot && (frmCnt == '0);
    stb.sfEnd     = lastBit && lastFrm;
    stb.flipPay   = berPend && !fSlot;
    stb.flipFrm   = ferPend && patSlot;
    stb.flipCrc   = crcPend && crcSlot;
    stb.idleFbit  = (bitCnt == '0);
    stb.idleFval  = SF_FBITS[idleFrm];
    stb.idleIdx   = bitCnt[2:0] - 3'd1;
    stb.idleStart = (bitCnt == '0) && (idleFrm == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      frmCnt  <= '0;
      idleFrm <= '0;
      berQ    <= 1'b0;
      ferQ    <= 1'b0;
      crcQ    <= 1'b0;
      berPend <= 1'b0;
      ferPend <= 1'b0;
      crcPend <= 1'b0;
    end else begin
      berQ <= berTrig;
      ferQ <= ferCtl;
      crcQ <= crcCtl;
      berPend <= berRise || (berPend && !(bitEn && stb.flipPay));
      ferPend <= ferRise || (ferPend && !(bitEn && stb.flipFrm));
      crcPend <= crcRise || (crcPend && !(bitEn && stb.flipCrc));
      if (bitEn) begin
        if (lastBit) begin
          bitCnt  <= '0;
          frmCnt  <= lastFrm ? '0 : frmCnt + 1'b1;
          idleFrm <= (idleFrm == IDLE_LAST) ? '0 : idleFrm + 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ds1_tpg_dp.sv
module ds1_tpg_dp
  import ds1_tpg_pkg::*;
#(
  parameter logic [PRBS_W-1:0] PRBS_SEED  = '1,
  parameter logic [7:0]        IDLE_OCTET = 8'h7F
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    patSel,
  input  strobe_t stb,
  output logic    txData,
  output logic    txSync,
  output logic    lineClk,
  output logic    idleData,
  output logic    idleSync,
  output logic    idleClk
);

  logic [PRBS_W-1:0] prbs;
  logic [CRC_W-1:0]  crcRun, crcHold, crcNext;
  logic [7:0]        crcPad;
  logic payTx, frmTx, bitOut, crcIn, idleBit;

  always_comb begin
    crcPad  = {{(8 - CRC_W){1'b0}}, crcHold};
    payTx   = (patSel ? 1'b1 : prbs[PRBS_W-1]) ^ stb.flipPay;
    frmTx   = stb.crcSlot ? (crcPad[3'd5 - stb.crcIdx] ^ stb.flipCrc)
                          : (stb.fbitVal ^ stb.flipFrm);
    bitOut  = stb.payload ? payTx : frmTx;
    crcIn   = stb.payload ? payTx : 1'b1;
    crcNext = {crcRun[CRC_W-2:0], 1'b0} ^ ({CRC_W{crcRun[CRC_W-1] ^ crcIn}} & CRC_POLY);
    idleBit = stb.idleFbit ? stb.idleFval : IDLE_OCTET[3'd7 - stb.idleIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prbs     <= PRBS_SEED;
      crcRun   <= '0;
      crcHold  <= '0;
      txData   <= 1'b0;
      txSync   <= 1'b0;
      lineClk  <= 1'b0;
      idleData <= 1'b0;
      idleSync <= 1'b0;
      idleClk  <= 1'b0;
    end else begin
      lineClk  <= stb.adv;
      idleClk  <= stb.adv;
      txSync   <= stb.adv && stb.sfStart;
      idleSync <= stb.adv && stb.idleStart;
      if (stb.adv) begin
        txData   <= bitOut;
        idleData <= idleBit;
        if (stb.payload)
          prbs <= {prbs[PRBS_W-2:0], prbs[PRBS_W-1] ^ prbs[PRBS_W-2]};
        if (stb.sfEnd) begin
          crcHold <= crcNext;
          crcRun  <= '0;
        end else begin
          crcRun <= crcNext;
        end
      end
    end
  end

endmodule

// File: rtl/ds1_pattern_gen.sv
module ds1_pattern_gen
  import ds1_tpg_pkg::*;
#(
  parameter logic [PRBS_W-1:0] PRBS_SEED  = '1,
  parameter logic [7:0]        IDLE_OCTET = 8'h7F
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic [1:0] frameMode,
  input  logic       patSel,
  input  logic       berEnable,
  input  logic       berTrig,
  input  logic       ferCtl,
  input  logic       crcCtl,
  output logic       txData,
  output logic       txSync,
  output logic       lineClk,
  output logic       idleData,
  output logic       idleSync,
  output logic       idleClk
);

  strobe_t stb;

  ds1_tpg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .frameMode (frameMode),
    .berEnable (berEnable),
    .berTrig   (berTrig),
    .ferCtl    (ferCtl),
    .crcCtl    (crcCtl),
    .stb       (stb)
  );

  ds1_tpg_dp #(
    .PRBS_SEED  (PRBS_SEED),
    .IDLE_OCTET (IDLE_OCTET)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .patSel   (patSel),
    .stb      (stb),
    .txData   (txData),
    .txSync   (txSync),
    .lineClk  (lineClk),
    .idleData (idleData),
    .idleSync (idleSync),
    .idleClk  (idleClk)
  );

endmodule

// File: rtl/ds1_pattern_gen_chk.sv
module ds1_pattern_gen_chk (
  input logic       clk,
  input logic       rstN,
  input logic       bitEn,
  input logic [1:0] frameMode,
  input logic       txData,
  input logic       txSync,
  input logic       lineClk,
  input logic       idleData,
  input logic       idleSync,
  input logic       idleClk
);

  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    txSync |=> !txSync); // R6

  AST_UNFRAMED_NOSYNC: assert property (@(posedge clk) disable iff (!rstN)
    (frameMode == 2'b00 || frameMode == 2'b11) |=> !txSync); // R2

  AST_IDLE_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    idleSync |=> !idleSync); // R11

  AST_IDLE_SYNC_FBIT: assert property (@(posedge clk) disable iff (!rstN)
    idleSync |-> idleData); // R11

  AST_HOLD_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(txData) && $stable(idleData) && !lineClk && !idleClk)); // R10

  AST_STROBE_PER_BIT: assert property (@(posedge clk) disable iff (!rstN)
    bitEn |=> (lineClk && idleClk)); // R10

endmodule

bind ds1_pattern_gen ds1_pattern_gen_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bitEn     (bitEn),
  .frameMode (frameMode),
  .txData    (txData),
  .txSync    (txSync),
  .lineClk   (lineClk),
  .idleData  (idleData),
  .idleSync  (idleSync),
  .idleClk   (idleClk)
);

// File: tb/ds1_pattern_gen_test.sv
module ds1_pattern_gen_test;

  localparam logic [14:0] SEED = 15'h1234;
  localparam logic [7:0]  IDLE = 8'h7F;
  localparam logic [11:0] SFB  = 12'b0011_1011_0001; // frame0 in bit0
  localparam logic [5:0]  FPS  = 6'b110100;          // slot0 in bit0

  logic clk = 1'b0;
  logic rstN = 1'b0, bitEn = 1'b0, patSel = 1'b0;
  logic [1:0] frameMode = 2'b00;
  logic berEnable = 1'b0, berTrig = 1'b0, ferCtl = 1'b0, crcCtl = 1'b0;
  logic txData, txSync, lineClk, idleData, idleSync, idleClk;

  int chkCnt = 0, errCnt = 0, syncSeen = 0;

  // model state
  int mb, mf, imf;
  logic [14:0] mprbs;
  logic [5:0] mcrc, mhold;
  bit mBer, mFer, mCrc;

  always #10 clk = ~clk;

  ds1_pattern_gen #(.PRBS_SEED(SEED), .IDLE_OCTET(IDLE)) uut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameMode(frameMode), .patSel(patSel),
    .berEnable(berEnable), .berTrig(berTrig), .ferCtl(ferCtl), .crcCtl(crcCtl),
    .txData(txData), .txSync(txSync), .lineClk(lineClk),
    .idleData(idleData), .idleSync(idleSync), .idleClk(idleClk)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic modelStep(output logic eD, output logic eS,
                           output logic iD, output logic iS);
    bit framed = (frameMode == 2'b01) || (frameMode == 2'b10);
    bit esf = (frameMode == 2'b10);
    bit fslot = framed && (mb == 0);
    logic cin, p, fb;
    if (!fslot) begin
      p = patSel ? 1'b1 : mprbs[14];
      mprbs = {mprbs[13:0], mprbs[14] ^ mprbs[13]};
      if (mBer) begin p = ~p; mBer = 0; end
      eD = p; cin = p;
    end else begin
      cin = 1'b1;
      if (esf && (mf % 4 == 1)) begin
        eD = mhold[5 - mf / 4];
        if (mCrc) begin eD = ~eD; mCrc = 0; end
      end else if (esf) begin
        eD = (mf % 4 == 3) ? FPS[mf / 4] : 1'b1;
        if ((mf % 4 == 3) && mFer) begin eD = ~eD; mFer = 0; end
      end else begin
        eD = SFB[mf];
        if (mFer) begin eD = ~eD; mFer = 0; end
      end
    end
    eS = fslot && (mf == 0);
    iD = (mb == 0) ? SFB[imf] : IDLE[7 - ((mb - 1) % 8)];
    iS = (mb == 0) && (imf == 0);
    fb = mcrc[5] ^ cin;
    mcrc = {mcrc[4:0], 1'b0} ^ (fb ? 6'h03 : 6'h00);
    if (mb == 192 && mf == (esf ? 23 : 11)) begin mhold = mcrc; mcrc = '0; end
    if (mb == 192) begin
      mb = 0;
      mf = (mf == (esf ? 23 : 11)) ? 0 : mf + 1;
      imf = (imf == 11) ? 0 : imf + 1;
    end else mb++;
  endtask

  task automatic doReset(input logic [1:0] mode, input logic pat);
    @(negedge clk);
    rstN = 1'b0; bitEn = 1'b0; frameMode = mode; patSel = pat;
    berTrig = 0; ferCtl = 0; crcCtl = 0; berEnable = 0;
    mb = 0; mf = 0; imf = 0; mprbs = SEED; mcrc = '0; mhold = '0;
    mBer = 0; mFer = 0; mCrc = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // run n bits, compare test stream and idle stream against the model
  task automatic runBits(input int n, input string req);
    int txErr = 0, idErr = 0;
    longint txA = 0, txE = 0, idA = 0, idE = 0;
    logic eD, eS, iD, iS;
    syncSeen = 0;
    bitEn = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      modelStep(eD, eS, iD, iS);
      @(negedge clk);
      if (txSync) syncSeen++;
      if ({txData, txSync, lineClk} !== {eD, eS, 1'b1}) begin
        if (txErr == 0) begin txA = {txData, txSync, lineClk}; txE = {eD, eS, 1'b1}; end
        txErr++;
      end
      if ({idleData, idleSync, idleClk} !== {iD, iS, 1'b1}) begin
        if (idErr == 0) begin idA = {idleData, idleSync, idleClk}; idE = {iD, iS, 1'b1}; end
        idErr++;
      end
    end
    bitEn = 1'b0;
    check(txErr == 0, req, "test stream {data,sync,clk}", txA, txE);
    check(idErr == 0, "R11", "idle stream {data,sync,clk}", idA, idE);
  endtask

  // 0: bit error, 1: framing error, 2: checksum error
  task automatic pulse(input int which);
    bit framed = (frameMode == 2'b01) || (frameMode == 2'b10);
    bitEn = 1'b0;
    case (which)
      0: begin berTrig = 1; if (berEnable) mBer = 1; end
      1: begin ferCtl = 1;  if (framed) mFer = 1; end
      default: begin crcCtl = 1; if (frameMode == 2'b10) mCrc = 1; end
    endcase
    @(negedge clk);
    berTrig = 0; ferCtl = 0; crcCtl = 0;
    @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check({txData, txSync, lineClk, idleData, idleSync, idleClk} === 6'b0,
          "R1", "outputs in reset",
          {txData, txSync, lineClk, idleData, idleSync, idleClk}, 0);
  endtask

  task automatic testUnframed();
    doReset(2'b00, 1'b0);
    runBits(600, "R2");
    check(syncSeen == 0, "R2", "sync pulses unframed", syncSeen, 0);
    doReset(2'b11, 1'b0);
    runBits(300, "R2");
  endtask

  task automatic testSf();
    doReset(2'b01, 1'b0);
    runBits(2 * 12 * 193, "R3");
    check(syncSeen == 2, "R6", "sync pulses in two superframes", syncSeen, 2);
  endtask

  task automatic testEsf();
    doReset(2'b10, 1'b0);
    runBits(3 * 24 * 193, "R4");
    check(syncSeen == 3, "R6", "sync pulses in three ESF superframes", syncSeen, 3);
  endtask

  task automatic testBitErr();
    doReset(2'b01, 1'b0);
    runBits(100, "R5");
    berEnable = 1'b1;
    pulse(0);
    runBits(300, "R5");
    berEnable = 1'b0;
    pulse(0);
    runBits(300, "R5");
  endtask

  task automatic testFrameErr();
    doReset(2'b01, 1'b0);
    runBits(50, "R7");
    pulse(1);
    runBits(400, "R7");
    doReset(2'b10, 1'b0);
    runBits(50, "R7");
    pulse(1);
    runBits(1000, "R7");
    doReset(2'b00, 1'b0);
    runBits(50, "R7");
    pulse(1);
    runBits(300, "R7");
  endtask

  task automatic testCrcErr();
    doReset(2'b10, 1'b0);
    runBits(24 * 193, "R8");
    pulse(2);
    runBits(2 * 24 * 193, "R8");
    doReset(2'b01, 1'b0);
    runBits(50, "R8");
    pulse(2);
    runBits(400, "R8");
  endtask

  task automatic testOnes();
    doReset(2'b00, 1'b1);
    runBits(300, "R9");
    doReset(2'b01, 1'b1);
    runBits(500, "R9");
  endtask

  task automatic testHold();
    logic d0, i0;
    int bad = 0;
    doReset(2'b01, 1'b0);
    runBits(37, "R10");
    d0 = txData; i0 = idleData;
    bitEn = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (txData !== d0 || idleData !== i0 || lineClk !== 1'b0 || idleClk !== 1'b0) bad++;
    end
    check(bad == 0, "R10", "hold while bitEn low (bad cycles)", bad, 0);
    runBits(400, "R10");
  endtask

  initial begin
    testReset();
    testUnframed();
    testSf();
    testEsf();
    testBitErr();
    testFrameErr();
    testCrcErr();
    testOnes();
    testHold();
    $display("Simulation finished: %0d checks, %0d errors", chkCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chkCnt++;
    errCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", chkCnt, errCnt);
    $finish;
  end

endmodule